// File: doc/BRIEF.md
# Vector-Chained Descriptor DMA Engine

This block moves data words between addresses of one shared synchronous memory on behalf of a set of peripheral request lines. Each request source owns one slot in a vector table held in writable memory. The slot holds a pointer to the descriptor that is active for that source. On a request the engine reads the slot, fetches the six-word descriptor, and copies either one element or the whole remaining count. It then writes the updated count and addresses back into the descriptor.

When a descriptor is exhausted and chaining is enabled, the engine overwrites the source's vector slot with the descriptor's link address. The following request from that source therefore runs from the next descriptor. In the same step the engine can raise a one-cycle completion interrupt, with the descriptor's handler address presented beside it.

The memory port is a fixed-latency SRAM port with no back-pressure. A read issued in one cycle returns its data in the next cycle, and a write completes in the cycle it is issued. A valid/ready handshake would carry no information on this port, so it has none. Request and interrupt pins are plain level signals.

Top module: `vchain_dma`

## Requirements
- R1: After reset the engine is idle, issues no memory access and holds the interrupt low until a request arrives.
- R2: For a request from source s, the first access is a read of the vector slot at VEC_BASE+s. The descriptor is then read from the pointer p held there: mode at p+0, count at p+1, source address at p+2, destination address at p+3, link address at p+4, handler address at p+5.
- R3: With mode bit1 (burst) clear, each request copies exactly one word, from the source address to the destination address.
- R4: After every transfer the engine writes back into the descriptor the remaining count (p+1), the source address advanced by the number of words moved (p+2), and the destination address advanced the same way (p+3).
- R5: With mode bit1 set, a single request copies consecutive words until the count reaches zero.
- R6: When the count reaches zero and mode bit0 (chain) is set, the link address is written into the source's vector slot, and the next request from that source uses the descriptor it names.
- R7: When the count reaches zero and mode bit0 is clear, the vector slot is left unchanged.
- R8: When the count reaches zero and mode bit2 (interrupt enable) is set, irq_o pulses high for exactly one cycle, in the same cycle as the link write when chaining is on, with irq_addr_o equal to the handler address. With bit2 clear no pulse is produced.
- R9: Requests that arrive while a transfer is in progress are held per source and served afterwards in ascending source-index order.
- R10: A request whose descriptor already has a count of zero moves no data, writes nothing back and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_SRC | Transfer request per source, sampled each cycle |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | W | Memory word address |
| mem_wdata_o | output | W | Write data |
| mem_rdata_i | input | W | Read data, valid the cycle after a read |
| irq_o | output | 1 | One-cycle completion interrupt |
| irq_addr_o | output | W | Handler address, valid while irq_o is high |

## Verification
The bench sets up a descriptor whose count is already zero and checks that a request against it leaves a sentinel destination word and the interrupt counter untouched. An engine that decremented first would wrap the count and corrupt memory. It follows a chained burst with a second request to the same source and checks that the data comes from the linked descriptor, which catches a slot rewrite that is skipped or aimed at the wrong source. Two requests to one shared destination, raised together while the engine is busy, must leave the higher-index source's word in place. A reversed or lost pending latch leaves the wrong value there. Single-step runs read the written-back count and addresses, so progress that is not persisted shows up as a repeated copy of the same word.

// File: rtl/vchain_pkg.sv
package vchain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_VEC, ST_DESC, ST_CHECK, ST_RD, ST_WR, ST_WB, ST_FIN
  } vc_state_e;

  localparam int MODE_CHAIN = 0;
  localparam int MODE_BURST = 1;
  localparam int MODE_IRQ   = 2;
  localparam int DESC_WORDS = 6;
  localparam int WB_WORDS   = 3;
endpackage

// File: rtl/vchain_pend.sv
module vchain_pend #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_o[i] <= 1'b0;
      else if (req_i[i])  pend_o[i] <= 1'b1;
      else if (clr_i[i])  pend_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/vchain_pick.sv
module vchain_pick #(
  parameter int N_SRC = 4,
  localparam int SW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] pend_i,
  output logic             any_o,
  output logic [SW-1:0]    idx_o,
  output logic [N_SRC-1:0] grant_o
);
  always_comb begin
    idx_o   = '0;
    grant_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        idx_o   = SW'(i);
        grant_o = N_SRC'(1) << i;
      end
    end
    any_o = |pend_i;
  end
endmodule

// File: rtl/vchain_dma.sv
module vchain_dma #(
  parameter int N_SRC    = 4,
  parameter int W        = 16,
  parameter int VEC_BASE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_i,
  output logic             mem_en_o,
  output logic             mem_we_o,
  output logic [W-1:0]     mem_addr_o,
  output logic [W-1:0]     mem_wdata_o,
  input  logic [W-1:0]     mem_rdata_i,
  output logic             irq_o,
  output logic [W-1:0]     irq_addr_o
);
  import vchain_pkg::*;
  localparam int SW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  vc_state_e         state_q, state_d;
  logic [SW-1:0]     src_q, pick_idx;
  logic [N_SRC-1:0]  pend, grant, clr;
  logic              pick_any;
  logic [W-1:0]      ptr_q, cnt_q, sa_q, da_q, link_q, hnd_q;
  logic [2:0]        mode_q;
  logic [2:0]        idx_q;
  logic [W-1:0]      cnt_dec;

  vchain_pend #(.N_SRC(N_SRC)) pend_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr), .pend_o(pend));

  vchain_pick #(.N_SRC(N_SRC)) pick_i (
    .pend_i(pend), .any_o(pick_any), .idx_o(pick_idx), .grant_o(grant));

  assign cnt_dec = cnt_q - W'(1);

  always_comb begin
    state_d     = state_q;
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    clr         = '0;
    irq_o       = 1'b0;
    irq_addr_o  = '0;
    unique case (state_q)
      ST_IDLE: if (pick_any) begin
        clr        = grant;
        mem_en_o   = 1'b1;
        mem_addr_o = W'(VEC_BASE) + W'(pick_idx);
        state_d    = ST_VEC;
      end
      ST_VEC: begin
        mem_en_o   = 1'b1;
        mem_addr_o = mem_rdata_i;
        state_d    = ST_DESC;
      end
      ST_DESC: begin
        if (idx_q == 3'(DESC_WORDS - 1)) state_d = ST_CHECK;
        else begin
          mem_en_o   = 1'b1;
          mem_addr_o = ptr_q + W'(idx_q) + W'(1);
        end
      end
      ST_CHECK: state_d = (cnt_q == '0) ? ST_IDLE : ST_RD;
      ST_RD: begin
        mem_en_o   = 1'b1;
        mem_addr_o = sa_q;
        state_d    = ST_WR;
      end
      ST_WR: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = da_q;
        mem_wdata_o = mem_rdata_i;
        state_d     = (mode_q[MODE_BURST] && cnt_dec != '0) ? ST_RD : ST_WB;
      end
      ST_WB: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr_q + W'(idx_q) + W'(1);
        mem_wdata_o = (idx_q == 3'd0) ? cnt_q : (idx_q == 3'd1) ? sa_q : da_q;
        if (idx_q == 3'(WB_WORDS - 1)) state_d = (cnt_q == '0) ? ST_FIN : ST_IDLE;
      end
      ST_FIN: begin
        if (mode_q[MODE_CHAIN]) begin
          mem_en_o    = 1'b1;
          mem_we_o    = 1'b1;
          mem_addr_o  = W'(VEC_BASE) + W'(src_q);
          mem_wdata_o = link_q;
        end
        irq_o      = mode_q[MODE_IRQ];
        irq_addr_o = mode_q[MODE_IRQ] ? hnd_q : '0;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      ptr_q   <= '0;
      mode_q  <= '0;
      cnt_q   <= '0;
      sa_q    <= '0;
      da_q    <= '0;
      link_q  <= '0;
      hnd_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      case (state_q)
        ST_IDLE: if (pick_any) src_q <= pick_idx;
        ST_VEC: begin
          ptr_q <= mem_rdata_i;
          idx_q <= '0;
        end
        ST_DESC: begin
          case (idx_q)
            3'd0:    mode_q <= mem_rdata_i[2:0];
            3'd1:    cnt_q  <= mem_rdata_i;
            3'd2:    sa_q   <= mem_rdata_i;
            3'd3:    da_q   <= mem_rdata_i;
            3'd4:    link_q <= mem_rdata_i;
            default: hnd_q  <= mem_rdata_i;
          endcase
          idx_q <= idx_q + 3'd1;
        end
        ST_WR: begin
          cnt_q <= cnt_dec;
          sa_q  <= sa_q + W'(1);
          da_q  <= da_q + W'(1);
          idx_q <= '0;
        end
        ST_WB: idx_q <= idx_q + 3'd1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vchain_dma_chk.sv
module vchain_dma_chk #(
  parameter int N_SRC = 4,
  parameter int W     = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input vchain_pkg::vc_state_e state,
  input logic [N_SRC-1:0]     grant,
  input logic [W-1:0]         cnt,
  input logic [2:0]           mode,
  input logic                 mem_en_o,
  input logic                 mem_we_o,
  input logic                 irq_o
);
  import vchain_pkg::*;

  // R1
  wr_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_en_o);

  // R3
  copy_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && state == ST_WR) |-> $past(mem_en_o && !mem_we_o));

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R8
  irq_with_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && mode[MODE_CHAIN]) |-> mem_we_o);

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R10
  zero_count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHECK && cnt == '0) |=> (state == ST_IDLE && !mem_en_o && !irq_o));
endmodule

bind vchain_dma vchain_dma_chk #(.N_SRC(N_SRC), .W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .state(state_q), .grant(grant), .cnt(cnt_q),
  .mode(mode_q), .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .irq_o(irq_o));

// File: tb/vchain_dma_tb.sv
module vchain_dma_tb_top;
  localparam int N = 4;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic mem_en, mem_we, irq;
  logic [W-1:0] mem_addr, mem_wdata, irq_addr;
  logic [W-1:0] rdata = '0;
  logic [W-1:0] mem [256];
  int checks = 0, fails = 0, irq_cnt = 0;
  logic [W-1:0] irq_last = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vchain_dma #(.N_SRC(N), .W(W), .VEC_BASE(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mem_en_o(mem_en), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(rdata),
    .irq_o(irq), .irq_addr_o(irq_addr));

  always @(posedge clk)
    if (mem_en) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        rdata <= mem[mem_addr[7:0]];
    end

  always @(negedge clk)
    if (rst_n && irq) begin
      irq_cnt++;
      irq_last = irq_addr;
    end

  // each entry: {source index, data word}
  localparam logic [3:0][23:0] TBL = {
    {8'd3, 16'h3C3C}, {8'd2, 16'hA5A5}, {8'd1, 16'h0F0F}, {8'd0, 16'h1234}};

  task automatic chk(string rq, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic set_desc(int p, int md, int cnt, int sa, int da, int lk, int hd);
    mem[p]   = W'(md);  mem[p+1] = W'(cnt); mem[p+2] = W'(sa);
    mem[p+3] = W'(da);  mem[p+4] = W'(lk);  mem[p+5] = W'(hd);
  endtask

  task automatic pulse(logic [N-1:0] m);
    @(negedge clk); req = m;
    @(negedge clk); req = '0;
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {15'd0, mem_en}, 16'd0);
    chk("R1", {15'd0, irq}, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", {15'd0, mem_en}, 16'd0);

    // R2 R3 R4: table of single copies, one per source
    for (int k = 0; k < 4; k++) begin
      int s, p;
      s = int'(TBL[k][23:16]);
      p = 16 + 8 * k;
      mem[s] = W'(p);
      mem[128 + k] = TBL[k][15:0];
      set_desc(p, 0, 1, 128 + k, 192 + k, 0, 0);
      pulse(N'(1) << s);
      settle();
      chk("R3", mem[192 + k], TBL[k][15:0]);
      chk("R4", mem[p + 1], 16'd0);
      chk("R4", mem[p + 2], W'(129 + k));
    end

    // R3 R4 R7 R8 R10: single-step, three requests, then one at count zero
    mem[0] = 16'd64;
    mem[140] = 16'h1111; mem[141] = 16'h2222; mem[142] = 16'h3333;
    mem[203] = 16'hDEAD;
    set_desc(64, 0, 3, 140, 200, 96, 16'h0777);
    pulse(4'b0001); settle();
    chk("R3", mem[200], 16'h1111);
    chk("R3", mem[201], 16'h0000);
    chk("R4", mem[65], 16'd2);
    chk("R4", mem[67], 16'd201);
    pulse(4'b0001); settle();
    pulse(4'b0001); settle();
    chk("R3", mem[202], 16'h3333);
    chk("R7", mem[0], 16'd64);
    chk("R8", W'(irq_cnt), 16'd0);
    pulse(4'b0001); settle();
    chk("R10", mem[203], 16'hDEAD);
    chk("R10", mem[65], 16'd0);
    chk("R10", W'(irq_cnt), 16'd0);

    // R5 R6 R8: burst with chain and interrupt, then the linked descriptor
    mem[1] = 16'd80;
    for (int i = 0; i < 4; i++) mem[144 + i] = W'(16'h5000 + i);
    mem[150] = 16'hBEEF;
    set_desc(80, 7, 4, 144, 208, 104, 16'h0ABC);
    set_desc(104, 0, 1, 150, 220, 0, 0);
    pulse(4'b0010); settle();
    for (int i = 0; i < 4; i++) chk("R5", mem[208 + i], W'(16'h5000 + i));
    chk("R5", mem[81], 16'd0);
    chk("R6", mem[1], 16'd104);
    chk("R8", W'(irq_cnt), 16'd1);
    chk("R8", irq_last, 16'h0ABC);
    pulse(4'b0010); settle();
    chk("R6", mem[220], 16'hBEEF);
    chk("R8", W'(irq_cnt), 16'd1);

    // R9: pending requests served in ascending order
    mem[1] = 16'd112; mem[2] = 16'd120; mem[3] = 16'd40;
    mem[152] = 16'h0001; mem[153] = 16'h0002; mem[154] = 16'h0003;
    set_desc(112, 0, 1, 152, 230, 0, 0);
    set_desc(120, 0, 1, 153, 231, 0, 0);
    set_desc(40, 0, 1, 154, 230, 0, 0);
    pulse(4'b0100);
    @(negedge clk);
    pulse(4'b1010);
    settle(); settle();
    chk("R9", mem[230], 16'h0003);
    chk("R9", mem[231], 16'h0002);
    chk("R9", mem[41], 16'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule